// File: doc/BRIEF.md
# Virtually indexed, physically tagged write-back data cache

This block is a direct-mapped 8 KiB level-one data cache with 16-byte lines and 32-bit words. A request brings only the low virtual address bits: the byte offset and the set index. The tag and data arrays are read with the virtual set index while the address translation is still being resolved. The translated physical page number then arrives on a separate port and is compared with the stored physical tag. Loads return either a whole word or a single zero-extended byte. Stores write bytes under a byte-enable mask and mark the line dirty.

Pages are 4 KiB, so the top set-index bit lies above the page offset. It is a virtual bit and can differ from the physical bit at the same position. For this reason the stored tag holds every physical address bit above the page offset, including the bit that overlaps the top of the index. When a dirty line has to make room, its physical line address is rebuilt from the stored tag and the in-page part of the set index alone. That address is sent with the line on a write-back port, and the missing line is then fetched over a request/response refill port. The translation input plays no part in forming the victim address.

Top module: `vipt_wb_dcache`

## Requirements
- R1: After reset every line is invalid, so the first access to any set misses. Coming out of reset, `req_ready` is high and `rsp_valid`, `wb_valid` and `fill_req_valid` are low.
- R2: The set index is `req_vaddr[12:4]` and the word within the line is `req_vaddr[3:2]`. An access hits only when the line is valid and all 20 stored tag bits (physical address bits 31:12) equal `xlat_ppn`. This includes bit 12, which overlaps the top index bit.
- R3: A load hit raises `rsp_valid` for exactly one cycle. With `req_byte` low, `rsp_rdata` is the whole word. With `req_byte` high, `rsp_rdata` holds byte `req_vaddr[1:0]` in bits 7:0 and zeros above; byte 0 is bits 7:0 of the word.
- R4: A store hit writes byte lane i (bits 8i+7:8i) of the addressed word only where `req_be[i]` is set. It marks the line dirty, gives a one-cycle `rsp_valid`, and causes no write-back or refill traffic.
- R5: A miss on an invalid or clean line issues one refill request with address {`xlat_ppn`, `req_vaddr[11:4]`, 4'b0000}. The line returned on `fill_rsp_data` is installed clean, and the access then completes as a hit.
- R6: A miss on a valid dirty line first issues one write-back of that line's data, with word k in bits 32k+31:32k. Only after the write-back has been accepted is the refill request issued.
- R7: While `xlat_valid` is low during a lookup, the access stalls. No response, write-back or refill appears, and no cache state changes.
- R8: `wb_valid` and `fill_req_valid` are held, with stable addresses, until the matching ready is seen. Only one access is in progress at a time, and `req_ready` is low while it runs.
- R9: The write-back address is {stored tag, set index bits 7:0, 4'b0000}, whatever the translation presented at eviction time. A line whose physical bit 12 differs from its virtual index bit 12 is therefore written back to its own physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | Load returns one zero-extended byte |
| req_vaddr | input | 13 | Low virtual address bits (set index and line offset) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| xlat_valid | input | 1 | Translation result available for the current access |
| xlat_ppn | input | 20 | Translated physical page number |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | 32 | Physical line address of the victim |
| wb_data | output | 128 | Victim line data |
| fill_req_valid | output | 1 | Refill request |
| fill_req_ready | input | 1 | Refill request accepted |
| fill_req_addr | output | 32 | Physical line address to fetch |
| fill_rsp_valid | input | 1 | Refill data present (one cycle) |
| fill_rsp_data | input | 128 | Refill line data |

## Verification
The hardest case to reach from the ports is the eviction of a dirty line whose physical bit 12 differs from its virtual index bit 12. It is also the case that shows the stored tag alone gives the victim address. The stimulus produces it on purpose: it stores through virtual index bit 12 = 1 with a page number whose low bit is 0, then evicts that line with a different translation. A later reload confirms that the written-back bytes arrive at the rebuilt address. A pseudo-random run over a few conflicting sets and page numbers, with translation stalls of varying length, adds more dirty evictions. A behavioural model of the lines and of backing memory checks every response, write-back and refill against its own prediction.

// File: rtl/vipt_dc_pkg.sv
package vipt_dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_FWAIT,
    ST_RETRY
  } dc_state_t;
endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
  parameter int SETS  = 512,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vbits;
  logic [SETS-1:0]  dbits;

  // tag RAM: synchronous read, read-first
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // status bits in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits    <= '0;
      dbits    <= '0;
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else begin
      if (wr_en) begin
        vbits[wr_idx] <= 1'b1;
        dbits[wr_idx] <= wr_dirty;
      end
      rd_valid <= vbits[rd_idx];
      rd_dirty <= dbits[rd_idx];
    end
  end
endmodule

// File: rtl/vc_data_store.sv
module vc_data_store #(
  parameter int SETS   = 512,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int BE_W   = WORD_W / 8,
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic [WPL-1:0]    wr_word_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [LINE_W-1:0] wr_line
);
  // one RAM per word so a full line reads in one cycle
  for (genvar w = 0; w < WPL; w++) begin : g_bank
    logic [WORD_W-1:0] bank [SETS];
    always_ff @(posedge clk) begin
      if (wr_word_en[w]) begin
        for (int b = 0; b < BE_W; b++) begin
          if (wr_be[b]) bank[wr_idx][b*8 +: 8] <= wr_line[w*WORD_W + b*8 +: 8];
        end
      end
      rd_line[w*WORD_W +: WORD_W] <= bank[rd_idx];
    end
  end
endmodule

// File: rtl/vc_lane_pick.sv
module vc_lane_pick #(
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  localparam int WSEL_W = $clog2(WPL),
  localparam int BSEL_W = $clog2(WORD_W / 8),
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic [LINE_W-1:0] line,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [BSEL_W-1:0] bsel,
  input  logic              byte_mode,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] word;
  always_comb begin
    word = line[wsel*WORD_W +: WORD_W];
    if (byte_mode) result = {{(WORD_W-8){1'b0}}, word[bsel*8 +: 8]};
    else           result = word;
  end
endmodule

// File: rtl/vipt_wb_dcache.sv
module vipt_wb_dcache
  import vipt_dc_pkg::*;
#(
  parameter int PA_W        = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int WORD_W      = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SETS   = CACHE_BYTES / LINE_BYTES,
  localparam int IDX_W  = $clog2(SETS),
  localparam int VLO_W  = OFF_W + IDX_W,
  localparam int PG_W   = $clog2(PAGE_BYTES),
  localparam int PPN_W  = PA_W - PG_W,
  localparam int LOW_W  = PG_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WPL    = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WPL),
  localparam int BE_W   = WORD_W / 8,
  localparam int BSEL_W = $clog2(BE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [VLO_W-1:0]  req_vaddr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              xlat_valid,
  input  logic [PPN_W-1:0]  xlat_ppn,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [PA_W-1:0]   wb_addr,
  output logic [LINE_W-1:0] wb_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [PA_W-1:0]   fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [LINE_W-1:0] fill_rsp_data
);
  dc_state_t st;

  logic [VLO_W-1:0]  cap_va;
  logic              cap_write, cap_byte;
  logic [WORD_W-1:0] cap_wdata;
  logic [BE_W-1:0]   cap_be;
  logic [PPN_W-1:0]  cap_ppn;

  logic              rsp_valid_q, wb_valid_q, fill_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;
  logic [PA_W-1:0]   wb_addr_q, fill_addr_q;
  logic [LINE_W-1:0] wb_data_q;

  logic [IDX_W-1:0]  rd_idx, cur_idx;
  logic [WSEL_W-1:0] cur_wsel;
  logic [BSEL_W-1:0] cur_bsel;
  logic [PPN_W-1:0]  t_tag;
  logic              t_valid, t_dirty;
  logic [LINE_W-1:0] line_q;
  logic [WORD_W-1:0] picked;
  logic              hit;

  logic              tag_we, tag_wdirty;
  logic [PPN_W-1:0]  tag_wtag;
  logic [WPL-1:0]    dat_we;
  logic [BE_W-1:0]   dat_be;
  logic [LINE_W-1:0] dat_wline;

  assign cur_idx  = cap_va[OFF_W +: IDX_W];
  assign cur_wsel = cap_va[BSEL_W +: WSEL_W];
  assign cur_bsel = cap_va[BSEL_W-1:0];

  // arrays are addressed by virtual index; translation runs alongside
  assign rd_idx = (st == ST_IDLE) ? req_vaddr[OFF_W +: IDX_W] : cur_idx;

  // full physical page number compared, including the bit above the page offset
  assign hit = t_valid && (t_tag == xlat_ppn);

  vc_tag_store #(.SETS(SETS), .TAG_W(PPN_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_tag(t_tag), .rd_valid(t_valid),
    .rd_dirty(t_dirty), .wr_en(tag_we), .wr_idx(cur_idx), .wr_tag(tag_wtag),
    .wr_dirty(tag_wdirty)
  );

  vc_data_store #(.SETS(SETS), .WORD_W(WORD_W), .WPL(WPL)) u_data (
    .clk(clk), .rd_idx(rd_idx), .rd_line(line_q), .wr_word_en(dat_we),
    .wr_idx(cur_idx), .wr_be(dat_be), .wr_line(dat_wline)
  );

  vc_lane_pick #(.WORD_W(WORD_W), .WPL(WPL)) u_pick (
    .line(line_q), .wsel(cur_wsel), .bsel(cur_bsel), .byte_mode(cap_byte),
    .result(picked)
  );

  // array write sources: store hit or refill
  always_comb begin
    tag_we     = 1'b0;
    tag_wtag   = cap_ppn;
    tag_wdirty = 1'b0;
    dat_we     = '0;
    dat_be     = '1;
    dat_wline  = fill_rsp_data;
    if (st == ST_LOOK && xlat_valid && hit && cap_write) begin
      tag_we           = 1'b1;
      tag_wtag         = t_tag;
      tag_wdirty       = 1'b1;
      dat_we[cur_wsel] = 1'b1;
      dat_be           = cap_be;
      dat_wline        = {WPL{cap_wdata}};
    end else if (st == ST_FWAIT && fill_rsp_valid) begin
      tag_we = 1'b1;
      dat_we = '1;
    end
  end

  // control state and handshake flags
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      rsp_valid_q  <= 1'b0;
      wb_valid_q   <= 1'b0;
      fill_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st)
        ST_IDLE:  if (req_valid) st <= ST_LOOK;
        ST_LOOK: begin
          if (xlat_valid) begin
            if (hit) begin
              rsp_valid_q <= 1'b1;
              st          <= ST_IDLE;
            end else if (t_valid && t_dirty) begin
              wb_valid_q <= 1'b1;
              st         <= ST_EVICT;
            end else begin
              fill_valid_q <= 1'b1;
              st           <= ST_FILL;
            end
          end
        end
        ST_EVICT: begin
          if (wb_ready) begin
            wb_valid_q   <= 1'b0;
            fill_valid_q <= 1'b1;
            st           <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_req_ready) begin
            fill_valid_q <= 1'b0;
            st           <= ST_FWAIT;
          end
        end
        ST_FWAIT: if (fill_rsp_valid) st <= ST_RETRY;
        default:  st <= ST_LOOK;
      endcase
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (st == ST_IDLE && req_valid) begin
      cap_va    <= req_vaddr;
      cap_write <= req_write;
      cap_byte  <= req_byte;
      cap_wdata <= req_wdata;
      cap_be    <= req_be;
    end
    if (st == ST_LOOK && xlat_valid) begin
      rsp_rdata_q <= cap_write ? '0 : picked;
      if (!hit) begin
        cap_ppn     <= xlat_ppn;
        fill_addr_q <= {xlat_ppn, cap_va[OFF_W +: LOW_W], {OFF_W{1'b0}}};
        // victim address from stored tag and in-page index bits only
        wb_addr_q   <= {t_tag, cur_idx[LOW_W-1:0], {OFF_W{1'b0}}};
        wb_data_q   <= line_q;
      end
    end
  end

  assign req_ready      = (st == ST_IDLE);
  assign rsp_valid      = rsp_valid_q;
  assign rsp_rdata      = rsp_rdata_q;
  assign wb_valid       = wb_valid_q;
  assign wb_addr        = wb_addr_q;
  assign wb_data        = wb_data_q;
  assign fill_req_valid = fill_valid_q;
  assign fill_req_addr  = fill_addr_q;
endmodule

// File: rtl/vipt_wb_dcache_chk.sv
module vipt_wb_dcache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            xlat_valid,
  input logic            rsp_valid,
  input logic            wb_valid,
  input logic            wb_ready,
  input logic [PA_W-1:0] wb_addr,
  input logic            fill_req_valid,
  input logic            fill_req_ready,
  input logic [PA_W-1:0] fill_req_addr
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !wb_valid && !fill_req_valid && !rsp_valid)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !fill_req_valid); // R6
  AST_WB_NEEDS_XLAT: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_valid) |-> $past(xlat_valid)); // R7
  AST_RSP_NEEDS_XLAT: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(xlat_valid)); // R7
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr))); // R8
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr))); // R8
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (wb_valid || fill_req_valid) |-> !req_ready); // R8
endmodule

bind vipt_wb_dcache vipt_wb_dcache_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .xlat_valid(xlat_valid),
  .rsp_valid(rsp_valid), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .fill_req_valid(fill_req_valid),
  .fill_req_ready(fill_req_ready), .fill_req_addr(fill_req_addr)
);

// File: tb/vipt_wb_dcache_bench.sv
module vipt_wb_dcache_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [12:0] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic xlat_valid = 0;
  logic [19:0] xlat_ppn = '0;
  logic req_ready, rsp_valid, wb_valid, fill_req_valid;
  logic [31:0] rsp_rdata, wb_addr, fill_req_addr;
  logic [127:0] wb_data;
  logic wb_ready = 0, fill_req_ready = 0, fill_rsp_valid = 0;
  logic [127:0] fill_rsp_data = '0;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  vipt_wb_dcache u_vipt_wb_dcache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_vaddr(req_vaddr),
    .req_wdata(req_wdata), .req_be(req_be), .xlat_valid(xlat_valid),
    .xlat_ppn(xlat_ppn), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_rsp_valid(fill_rsp_valid),
    .fill_rsp_data(fill_rsp_data)
  );

  // behavioural model of lines and backing memory
  bit           m_v [512];
  bit           m_d [512];
  logic [19:0]  m_tag [512];
  logic [127:0] m_line [512];
  logic [127:0] mem [logic [31:0]];

  function automatic logic [127:0] mem_get(logic [31:0] pa);
    if (mem.exists(pa)) return mem[pa];
    return {pa ^ 32'hA5A5_0003, pa ^ 32'h3C3C_0002, pa ^ 32'h0F0F_0001, pa ^ 32'h1234_0000};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(bit wr, bit byt, logic [12:0] va, logic [31:0] wd,
                            logic [3:0] be, logic [19:0] ppn, int stall, string rq);
    logic [8:0] set;
    bit hit, exp_wb, exp_fill, done, wb_hold, wb_got, fill_hold, fill_got, fill_go, bad;
    logic [31:0] exp_wb_addr, exp_fill_addr, word, exp_rd;
    logic [127:0] exp_wb_data, exp_fill_data;
    set = va[12:4];
    hit = m_v[set] && (m_tag[set] == ppn);
    exp_wb = !hit && m_v[set] && m_d[set];
    exp_fill = !hit;
    exp_wb_addr = {m_tag[set], va[11:4], 4'h0};
    exp_wb_data = m_line[set];
    exp_fill_addr = {ppn, va[11:4], 4'h0};
    exp_fill_data = '0;
    if (exp_wb) mem[exp_wb_addr] = m_line[set];
    if (exp_fill) begin
      exp_fill_data = mem_get(exp_fill_addr);
      m_line[set] = exp_fill_data; m_tag[set] = ppn; m_v[set] = 1; m_d[set] = 0;
    end
    word = m_line[set][va[3:2]*32 +: 32];
    exp_rd = byt ? {24'h0, word[va[1:0]*8 +: 8]} : word;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) m_line[set][va[3:2]*32 + b*8 +: 8] = wd[b*8 +: 8];
      m_d[set] = 1;
    end

    @(negedge clk);
    chk(req_ready && !wb_valid && !fill_req_valid && !rsp_valid, "R8 idle before access",
        {req_ready, wb_valid, fill_req_valid, rsp_valid}, 4'b1000);
    req_valid = 1; req_write = wr; req_byte = byt; req_vaddr = va; req_wdata = wd;
    req_be = be; xlat_ppn = ppn; xlat_valid = (stall == 0);
    @(negedge clk);
    req_valid = 0;
    done = 0; wb_hold = 0; wb_got = 0; fill_hold = 0; fill_got = 0; fill_go = 0; bad = 0;
    for (int n = 0; n < 400 && !done; n++) begin
      wb_ready = 0; fill_req_ready = 0; fill_rsp_valid = 0;
      if (fill_go) begin fill_rsp_valid = 1; fill_rsp_data = exp_fill_data; fill_go = 0; end
      xlat_valid = (n >= stall);
      if (n <= stall && (wb_valid || fill_req_valid || rsp_valid)) begin
        chk(0, "R7 activity during translation stall", {wb_valid, fill_req_valid, rsp_valid}, 0);
        bad = 1;
      end
      if (rsp_valid) begin
        done = 1;
        if (!wr) chk(rsp_rdata == exp_rd, byt ? "R3 byte load" : "R3 word load", rsp_rdata, exp_rd);
      end
      if (wb_valid) begin
        if (!exp_wb || wb_got) begin
          if (!bad) chk(0, "R8 unexpected write-back", wb_addr, 0);
          bad = 1;
        end else if (!wb_hold) begin
          chk(wb_addr == exp_wb_addr, "R9 write-back address", wb_addr, exp_wb_addr);
          chk(wb_data == exp_wb_data, "R6 write-back data", wb_data, exp_wb_data);
          wb_hold = 1;
        end else begin
          wb_ready = 1; wb_got = 1;
        end
      end
      if (fill_req_valid) begin
        if (exp_wb && !wb_got) begin
          if (!bad) chk(0, "R6 refill before write-back", fill_req_addr, exp_wb_addr);
          bad = 1;
        end else if (!exp_fill || fill_got) begin
          if (!bad) chk(0, "R8 unexpected refill", fill_req_addr, 0);
          bad = 1;
        end else if (!fill_hold) begin
          chk(fill_req_addr == exp_fill_addr, "R5 refill address", fill_req_addr, exp_fill_addr);
          fill_hold = 1;
        end else begin
          fill_req_ready = 1; fill_got = 1; fill_go = 1;
        end
      end
      @(negedge clk);
    end
    wb_ready = 0; fill_req_ready = 0; fill_rsp_valid = 0; xlat_valid = 0;
    chk(done, wr ? "R4 store completes" : "R3 load completes", done, 1);
    chk(wb_got == exp_wb, "R6 write-back count", wb_got, exp_wb);
    chk(fill_got == exp_fill, hit ? "R2 hit gives no refill" : "R5 miss gives refill", fill_got, exp_fill);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [8:0] sets [4];
    logic [19:0] ppns [3];
    for (int i = 0; i < 512; i++) begin m_v[i] = 0; m_d[i] = 0; m_tag[i] = '0; m_line[i] = '0; end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!wb_valid, "R1 no write-back after reset", wb_valid, 0);
    chk(!fill_req_valid, "R1 no refill after reset", fill_req_valid, 0);
    chk(!rsp_valid, "R1 no response after reset", rsp_valid, 0);

    run_access(0, 0, 13'h1040, 0, 0, 20'h00055, 0, "R1");      // invalid set misses
    run_access(0, 1, 13'h1043, 0, 0, 20'h00055, 0, "R3");      // byte 3 hit
    run_access(1, 0, 13'h1044, 32'hDEAD_BEEF, 4'b0101, 20'h00055, 0, "R4");
    run_access(0, 0, 13'h1044, 0, 0, 20'h00055, 0, "R4");
    run_access(0, 1, 13'h1046, 0, 0, 20'h00055, 0, "R3");
    run_access(0, 0, 13'h1048, 0, 0, 20'h00054, 0, "R2");      // differs only in bit 12
    run_access(0, 0, 13'h1044, 0, 0, 20'h00055, 0, "R6");      // reload written-back data
    // R9: virtual index bit 12 = 1, physical bit 12 = 0
    run_access(1, 0, 13'h1080, 32'h0BAD_F00D, 4'b1111, 20'h000AA, 0, "R9");
    run_access(0, 0, 13'h1088, 0, 0, 20'h000BB, 1, "R9");
    run_access(0, 0, 13'h1080, 0, 0, 20'h000AA, 2, "R9");
    // R7: stalls on miss and on store hit
    run_access(0, 0, 13'h0200, 0, 0, 20'h00123, 3, "R7");
    run_access(1, 1, 13'h0201, 32'h0000_7700, 4'b0010, 20'h00123, 4, "R7");
    run_access(0, 1, 13'h0201, 0, 0, 20'h00123, 0, "R7");

    sets[0] = 9'h004; sets[1] = 9'h104; sets[2] = 9'h00B; sets[3] = 9'h18B;
    ppns[0] = 20'h01230; ppns[1] = 20'h01231; ppns[2] = 20'h0ABC4;
    r = 32'h1ACE_B00C;
    for (int k = 0; k < 120; k++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      run_access(r[6], r[7], {sets[r[1:0]], r[3:2], r[5:4]}, r ^ 32'h5A5A_A5A5, r[11:8],
                 ppns[r[13:12] % 3], int'(r[15:14]) % 3, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule